// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register File

This block holds the programmable state of an interrupt redirection controller. It is reached over a simple memory-mapped port. Software never addresses a table entry directly. It first writes an 8-bit index into a select register, then reads or writes a 32-bit data window. The index picks one of three things: the controller identity word, a read-only version word, or one half of a 64-bit redirection entry. There is one entry per interrupt pin.

Each entry's contents are driven straight out to the interrupt engine on sideband buses. The engine owns the remote-IRR flag of level-triggered pins, and it sets or clears that flag through per-pin inputs. Whenever software rewrites an entry, the block raises a one-cycle rescan pulse for that pin. The engine then re-evaluates the pin and may deliver it again.

Entry layout (64 bits): vector in 7:0, delivery mode in 10:8, destination mode in 11, polarity in 13, remote-IRR in 14, trigger mode in 15 (1 = level), mask in 16, destination in 63:56.

Top module: `redir_regfile`

## Requirements
- R1: After reset, every entry holds only its mask bit (lower half reads 0x00010000, upper half reads 0). The select register and the identity field are zero, and `ent_mask` is all ones.
- R2: The select register sits at offset 0x00. A write keeps only bits 7:0 of the write data, and a read returns the index in bits 7:0 with all other bits zero.
- R3: Only address bits 7:0 are decoded, so upper address bits alias. An access whose address bits 3:0 are not zero is ignored and reads zero. Offsets other than 0x00 (select) and 0x10 (window) read zero and ignore writes.
- R4: A write of length 1 uses data bits 7:0 and a write of length 2 uses bits 15:0, both zero-extended to 32 bits. Lengths 4 and 8 use bits 31:0. Any other length drops the write.
- R5: Index 0 reads the 4-bit identity in bits 27:24, and a window write at index 0 loads it from data bits 27:24. Index 2 reads the same word, and writes to index 2 are ignored.
- R6: Index 1 reads (pin count − 1) in bits 23:16 and the version code 0x11 in bits 7:0, which is 0x00170011 for 24 pins. Writes to index 1 are ignored.
- R7: Index 0x10+2n reaches bits 31:0 of entry n, and index 0x11+2n reaches bits 63:32. The stored fields appear on `ent_flat`, `ent_mask` and `ent_level`.
- R8: Indexes 3 to 0x0F, and entry indexes n at or above the pin count, read zero. Writes to them change nothing and raise no rescan.
- R9: A write to an entry's lower half clears its remote-IRR bit, whatever data bit 14 holds. A write to the upper half leaves remote-IRR unchanged.
- R10: `rirr_set` sets and `rirr_clr` clears a pin's remote-IRR, and set wins over clear. A lower-half write in the same cycle wins over both.
- R11: One cycle after a window write to a valid entry, `rescan_pin` carries exactly that pin's bit for one cycle. It is zero in every other cycle.
- R12: Read data is registered. `bus_rdata` shows the value one clock after `bus_rd`, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_wdata | input | 64 | Write data |
| bus_wr | input | 1 | Write request |
| bus_len | input | 4 | Access length in bytes |
| bus_rd | input | 1 | Read request |
| bus_rdata | output | 32 | Read data, registered |
| ent_flat | output | PINS*64 | All entries, entry n in bits 64n+63:64n |
| ent_mask | output | PINS | Mask bit of each entry |
| ent_level | output | PINS | Trigger mode of each entry (1 = level) |
| ent_rirr | output | PINS | Remote-IRR flag of each entry |
| rirr_set | input | PINS | Engine request to set remote-IRR |
| rirr_clr | input | PINS | Engine request to clear remote-IRR |
| rescan_pin | output | PINS | One-cycle pulse after an entry write |

## Verification
The engine's remote-IRR update and a software write to the lower half of the same entry can land in the same clock. The bench first sets the flag on a level-triggered pin and shows that an upper-half write keeps it. It then drives `rirr_set` for that pin in the same cycle as a lower-half write, and expects the flag at zero together with a rescan pulse for that pin only. A second pass drives set and clear together without a bus write and expects the flag to end set.

// File: rtl/redir_pkg.sv
package redir_pkg;
   localparam int ENT_W     = 64;
   localparam int VEC_LSB   = 0;
   localparam int DLV_LSB   = 8;
   localparam int DMODE_BIT = 11;
   localparam int POL_BIT   = 13;
   localparam int RIRR_BIT  = 14;
   localparam int TRIG_BIT  = 15;
   localparam int MASK_BIT  = 16;
   localparam int DEST_LSB  = 56;

   localparam logic [ENT_W-1:0] ENT_RESET = 64'h1 << MASK_BIT;

   typedef enum logic [2:0] {
      IDX_ID   = 3'd0,
      IDX_VER  = 3'd1,
      IDX_ARB  = 3'd2,
      IDX_ENT  = 3'd3,
      IDX_NONE = 3'd4
   } idx_kind_e;

   function automatic logic len_ok(input logic [3:0] len);
      return (len == 4'd1) || (len == 4'd2) || (len == 4'd4) || (len == 4'd8);
   endfunction

   function automatic logic [31:0] len_extend(input logic [3:0] len, input logic [31:0] d);
      case (len)
         4'd1:    return {24'h0, d[7:0]};
         4'd2:    return {16'h0, d[15:0]};
         default: return d;
      endcase
   endfunction
endpackage

// File: rtl/redir_bus_dec.sv
module redir_bus_dec
   import redir_pkg::*;
#(
   parameter int          ADDR_W  = 12,
   parameter logic [7:0]  SEL_OFF = 8'h00,
   parameter logic [7:0]  WIN_OFF = 8'h10
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [63:0]       wdata,
   input  logic              wr,
   input  logic [3:0]        len,
   input  logic              rd,
   output logic              sel_wr,
   output logic              win_wr,
   output logic              sel_rd,
   output logic              win_rd,
   output logic [31:0]       data32
);
   initial begin
      if (ADDR_W < 8) $error("ADDR_W must cover the 8 decoded bits");
      if (SEL_OFF[3:0] != 4'h0 || WIN_OFF[3:0] != 4'h0) $error("offsets must be 16-byte aligned");
      if (SEL_OFF == WIN_OFF) $error("select and window offsets must differ");
   end

   logic [7:0] off;
   logic       aligned;
   logic       wr_ok;
   logic       unused_bits;

   assign off         = addr[7:0];
   assign aligned     = (off[3:0] == 4'h0);
   assign wr_ok       = wr && aligned && len_ok(len);
   assign unused_bits = ^{wdata[63:32], addr};

   assign data32 = len_extend(len, wdata[31:0]);
   assign sel_wr = wr_ok && (off == SEL_OFF);
   assign win_wr = wr_ok && (off == WIN_OFF);
   assign sel_rd = rd && aligned && (off == SEL_OFF);
   assign win_rd = rd && aligned && (off == WIN_OFF);
endmodule

// File: rtl/redir_index_dec.sv
module redir_index_dec
   import redir_pkg::*;
#(
   parameter int PINS  = 24,
   localparam int IDX_W = $clog2(PINS)
) (
   input  logic [7:0]       sel,
   output idx_kind_e        kind,
   output logic [IDX_W-1:0] ent_idx,
   output logic             upper
);
   initial begin
      if (PINS < 2 || PINS > 120) $error("PINS must lie in 2..120");
   end

   logic [6:0] raw;

   assign raw     = sel[7:1] - 7'd8;
   assign ent_idx = raw[IDX_W-1:0];
   assign upper   = sel[0];

   always_comb begin
      if (sel == 8'h00)                            kind = IDX_ID;
      else if (sel == 8'h01)                       kind = IDX_VER;
      else if (sel == 8'h02)                       kind = IDX_ARB;
      else if (sel >= 8'h10 && raw < 7'(PINS))     kind = IDX_ENT;
      else                                         kind = IDX_NONE;
   end
endmodule

// File: rtl/redir_entry.sv
module redir_entry
   import redir_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_lo,
   input  logic             we_hi,
   input  logic [31:0]      wdata,
   input  logic             rirr_set,
   input  logic             rirr_clr,
   output logic [ENT_W-1:0] bits,
   output logic             rescan
);
   logic [ENT_W-1:0] ent_q;
   logic             rescan_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_q    <= ENT_RESET;
         rescan_q <= 1'b0;
      end else begin
         rescan_q <= we_lo || we_hi;
         if (we_hi) ent_q[63:32] <= wdata;
         if (we_lo) begin
            ent_q[31:0]     <= wdata;
            ent_q[RIRR_BIT] <= 1'b0;
         end else if (rirr_set) begin
            ent_q[RIRR_BIT] <= 1'b1;
         end else if (rirr_clr) begin
            ent_q[RIRR_BIT] <= 1'b0;
         end
      end
   end

   assign bits   = ent_q;
   assign rescan = rescan_q;

   p_lo_clears_rirr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      we_lo |=> !bits[RIRR_BIT]);
   p_hi_keeps_rirr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (we_hi && !we_lo && !rirr_set && !rirr_clr) |=> $stable(bits[RIRR_BIT]));
   p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rirr_set && !we_lo) |=> bits[RIRR_BIT]);
endmodule

// File: rtl/redir_regfile.sv
module redir_regfile
   import redir_pkg::*;
#(
   parameter int         PINS     = 24,
   parameter int         ADDR_W   = 12,
   parameter logic [7:0] VERSION  = 8'h11,
   parameter logic [7:0] SEL_OFF  = 8'h00,
   parameter logic [7:0] WIN_OFF  = 8'h10,
   parameter bit         READ_REG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [63:0]         bus_wdata,
   input  logic                bus_wr,
   input  logic [3:0]          bus_len,
   input  logic                bus_rd,
   output logic [31:0]         bus_rdata,
   output logic [PINS*64-1:0]  ent_flat,
   output logic [PINS-1:0]     ent_mask,
   output logic [PINS-1:0]     ent_level,
   output logic [PINS-1:0]     ent_rirr,
   input  logic [PINS-1:0]     rirr_set,
   input  logic [PINS-1:0]     rirr_clr,
   output logic [PINS-1:0]     rescan_pin
);
   localparam int IDX_W = $clog2(PINS);
   localparam logic [7:0] TOP_PIN = 8'(PINS - 1);

   initial begin
      if (ENT_W != 64) $error("entry width must be 64");
   end

   logic              sel_wr, win_wr, sel_rd, win_rd;
   logic [31:0]       data32;
   logic [7:0]        sel_q;
   logic [3:0]        id_q;
   idx_kind_e         kind;
   logic [IDX_W-1:0]  ent_idx;
   logic              upper;
   logic [ENT_W-1:0]  ent_arr [PINS];
   logic [31:0]       rd_val;

   redir_bus_dec #(.ADDR_W(ADDR_W), .SEL_OFF(SEL_OFF), .WIN_OFF(WIN_OFF)) u_dec (
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .wr     (bus_wr),
      .len    (bus_len),
      .rd     (bus_rd),
      .sel_wr (sel_wr),
      .win_wr (win_wr),
      .sel_rd (sel_rd),
      .win_rd (win_rd),
      .data32 (data32)
   );

   redir_index_dec #(.PINS(PINS)) u_idx (
      .sel     (sel_q),
      .kind    (kind),
      .ent_idx (ent_idx),
      .upper   (upper)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= 8'h00;
         id_q  <= 4'h0;
      end else begin
         if (sel_wr) sel_q <= data32[7:0];
         if (win_wr && kind == IDX_ID) id_q <= data32[27:24];
      end
   end

   for (genvar g = 0; g < PINS; g++) begin : g_ent
      logic hit;
      assign hit = win_wr && (kind == IDX_ENT) && (ent_idx == IDX_W'(g));
      redir_entry u_ent (
         .clk      (clk),
         .rst_n    (rst_n),
         .we_lo    (hit && !upper),
         .we_hi    (hit && upper),
         .wdata    (data32),
         .rirr_set (rirr_set[g]),
         .rirr_clr (rirr_clr[g]),
         .bits     (ent_arr[g]),
         .rescan   (rescan_pin[g])
      );
      assign ent_flat[g*64 +: 64] = ent_arr[g];
      assign ent_mask[g]  = ent_arr[g][MASK_BIT];
      assign ent_level[g] = ent_arr[g][TRIG_BIT];
      assign ent_rirr[g]  = ent_arr[g][RIRR_BIT];
   end

   always_comb begin
      rd_val = 32'h0;
      if (sel_rd) begin
         rd_val = {24'h0, sel_q};
      end else if (win_rd) begin
         case (kind)
            IDX_ID, IDX_ARB: rd_val = {4'h0, id_q, 24'h0};
            IDX_VER:         rd_val = {8'h0, TOP_PIN, 8'h0, VERSION};
            IDX_ENT:         rd_val = upper ? ent_arr[ent_idx][63:32] : ent_arr[ent_idx][31:0];
            default:         rd_val = 32'h0;
         endcase
      end
   end

   if (READ_REG) begin : g_rd_reg
      logic [31:0] rdata_q;
      always_ff @(posedge clk) begin
         if (!rst_n)      rdata_q <= 32'h0;
         else if (bus_rd) rdata_q <= rd_val;
      end
      assign bus_rdata = rdata_q;
   end else begin : g_rd_comb
      assign bus_rdata = rd_val;
   end

   p_sel_low_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |=> sel_q == $past(bus_wdata[7:0]));
   p_id_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(win_wr && kind == IDX_ID) |=> $stable(id_q));
   p_single_rescan_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rescan_pin) <= 1);
   p_no_rescan_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !win_wr |=> rescan_pin == '0);
   p_out_of_range_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr && kind == IDX_NONE) |=> rescan_pin == '0);
endmodule

// File: tb/redir_regfile_bench.sv
module redir_regfile_bench;
   localparam int PINS = 24;
   localparam logic [11:0] A_SEL = 12'h000;
   localparam logic [11:0] A_WIN = 12'h010;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [11:0]       bus_addr = '0;
   logic [63:0]       bus_wdata = '0;
   logic              bus_wr = 1'b0;
   logic [3:0]        bus_len = 4'd4;
   logic              bus_rd = 1'b0;
   logic [31:0]       bus_rdata;
   logic [PINS*64-1:0] ent_flat;
   logic [PINS-1:0]   ent_mask, ent_level, ent_rirr, rescan_pin;
   logic [PINS-1:0]   rirr_set = '0;
   logic [PINS-1:0]   rirr_clr = '0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [31:0] exp_q [$];
   string       tag_q [$];
   logic        rd_seen = 1'b0;

   always #5 clk = ~clk;

   redir_regfile u_redir_regfile (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_len(bus_len), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .ent_flat(ent_flat), .ent_mask(ent_mask), .ent_level(ent_level),
      .ent_rirr(ent_rirr), .rirr_set(rirr_set), .rirr_clr(rirr_clr),
      .rescan_pin(rescan_pin)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops the expected read value one clock after the request
   always @(posedge clk) rd_seen <= bus_rd;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            checks++; failures++;
            $display("FAIL R12 unexpected read data actual=%h expected=none", bus_rdata);
         end else begin
            check(tag_q.pop_front(), 64'(bus_rdata), 64'(exp_q.pop_front()));
         end
      end
   end

   task automatic bus_write(input logic [11:0] a, input logic [63:0] d,
                            input logic [3:0] len, input logic [PINS-1:0] sv);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_len = len; bus_wr = 1'b1; rirr_set = sv;
      @(negedge clk);
      bus_wr = 1'b0; rirr_set = '0;
   endtask

   task automatic wr32(input logic [11:0] a, input logic [31:0] d);
      bus_write(a, {32'h0, d}, 4'd4, '0);
   endtask

   task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic pulse(input logic [PINS-1:0] s, input logic [PINS-1:0] c);
      @(negedge clk);
      rirr_set = s; rirr_clr = c;
      @(negedge clk);
      rirr_set = '0; rirr_clr = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 mask vector", 64'(ent_mask), 64'hFFFFFF);
      check("R1 rirr vector", 64'(ent_rirr), 64'h0);
      bus_read(A_SEL, 32'h0, "R1 select after reset");
      bus_read(A_WIN, 32'h0, "R1 id after reset");
      wr32(A_SEL, 32'h10);
      bus_read(A_WIN, 32'h00010000, "R1 entry0 lower after reset");
      wr32(A_SEL, 32'h3F);
      bus_read(A_WIN, 32'h0, "R1 entry23 upper after reset");

      // R2 select keeps low byte
      wr32(A_SEL, 32'h00001234);
      bus_read(A_SEL, 32'h34, "R2 select low byte");

      // R6 version, write ignored
      wr32(A_SEL, 32'h01);
      bus_read(A_WIN, 32'h00170011, "R6 version");
      wr32(A_WIN, 32'hFFFFFFFF);
      bus_read(A_WIN, 32'h00170011, "R6 version after write");

      // R5 identity and arbitration alias
      wr32(A_SEL, 32'h00);
      wr32(A_WIN, 32'hFBFFFFFF);
      bus_read(A_WIN, 32'h0B000000, "R5 id readback");
      wr32(A_SEL, 32'h02);
      bus_read(A_WIN, 32'h0B000000, "R5 arb reads id");
      wr32(A_WIN, 32'h00000000);
      wr32(A_SEL, 32'h00);
      bus_read(A_WIN, 32'h0B000000, "R5 arb write ignored");

      // R3 misaligned, aliasing, undecoded offsets
      bus_write(12'h004, 64'h20, 4'd4, '0);
      bus_read(A_SEL, 32'h00, "R3 misaligned write ignored");
      bus_read(12'h014, 32'h0, "R3 misaligned read zero");
      bus_write(12'h300, 64'h10, 4'd4, '0);
      bus_read(12'h700, 32'h10, "R3 upper address bits alias");
      bus_write(12'h020, 64'h11, 4'd4, '0);
      bus_read(A_SEL, 32'h10, "R3 undecoded write ignored");
      bus_read(12'h020, 32'h0, "R3 undecoded read zero");

      // R4 lengths on entry0 lower (select 0x10)
      bus_write(A_WIN, 64'hFFFFFFFF, 4'd1, '0);
      bus_read(A_WIN, 32'h000000FF, "R4 byte write");
      bus_write(A_WIN, 64'hFFFFFFFF, 4'd2, '0);
      bus_read(A_WIN, 32'h0000BFFF, "R4 halfword write rirr forced 0");
      bus_write(A_WIN, 64'hDEADBEEF00012345, 4'd8, '0);
      bus_read(A_WIN, 32'h00012345, "R4 eight-byte write");
      bus_write(A_WIN, 64'h0, 4'd3, '0);
      check("R4 bad length no rescan", 64'(rescan_pin), 64'h0);
      bus_read(A_WIN, 32'h00012345, "R4 bad length dropped");

      // R7 upper half, sideband fields
      wr32(A_SEL, 32'h11);
      wr32(A_WIN, 32'hAB000000);
      check("R7 dest field", 64'(ent_flat[63:56]), 64'hAB);
      check("R11 rescan pin0", 64'(rescan_pin), 64'h1);
      @(negedge clk);
      check("R11 rescan one cycle", 64'(rescan_pin), 64'h0);
      bus_read(A_WIN, 32'hAB000000, "R7 upper readback");
      wr32(A_SEL, 32'h3E);
      wr32(A_WIN, 32'h00000031);
      check("R11 rescan pin23", 64'(rescan_pin), 64'h800000);
      check("R7 vector pin23", 64'(ent_flat[23*64 +: 8]), 64'h31);
      check("R7 mask cleared pin23", 64'(ent_mask[23]), 64'h0);

      // R8 out of range and reserved indexes
      wr32(A_SEL, 32'h40);
      wr32(A_WIN, 32'h00000055);
      check("R8 out of range no rescan", 64'(rescan_pin), 64'h0);
      bus_read(A_WIN, 32'h0, "R8 out of range reads zero");
      wr32(A_SEL, 32'h05);
      wr32(A_WIN, 32'h00000055);
      check("R8 reserved no rescan", 64'(rescan_pin), 64'h0);
      bus_read(A_WIN, 32'h0, "R8 reserved reads zero");

      // R9/R10 remote-IRR on pin3
      wr32(A_SEL, 32'h16);
      wr32(A_WIN, 32'h00008033);
      check("R7 level pin3", 64'(ent_level[3]), 64'h1);
      pulse(24'h8, '0);
      check("R10 set", 64'(ent_rirr[3]), 64'h1);
      bus_read(A_WIN, 32'h0000C033, "R9 rirr visible in lower");
      wr32(A_SEL, 32'h17);
      wr32(A_WIN, 32'h01000000);
      check("R9 upper write keeps rirr", 64'(ent_rirr[3]), 64'h1);
      wr32(A_SEL, 32'h16);
      bus_write(A_WIN, 64'h00008033, 4'd4, 24'h8);
      check("R10 lower write beats set", 64'(ent_rirr[3]), 64'h0);
      check("R11 rescan pin3", 64'(rescan_pin), 64'h8);
      pulse(24'h8, 24'h8);
      check("R10 set beats clear", 64'(ent_rirr[3]), 64'h1);
      pulse('0, 24'h8);
      check("R10 clear", 64'(ent_rirr[3]), 64'h0);
      wr32(A_WIN, 32'h00004033);
      check("R9 written bit14 ignored", 64'(ent_rirr[3]), 64'h0);

      // R12 read data holds between reads
      bus_read(A_SEL, 32'h16, "R12 select read");
      repeat (3) @(negedge clk);
      check("R12 rdata holds", 64'(bus_rdata), 64'h16);

      repeat (2) @(negedge clk);
      check("R12 scoreboard drained", 64'(exp_q.size()), 64'h0);
      finish_run();
   end
endmodule